// File: doc/BRIEF.md
# Mode-Split Unsigned Multiplier Slice

This block is a multiplier slice whose one arithmetic datapath is divided by a static mode code. Depending on that code it produces three 9x9 products, two 16x16 products, or a single 18x18, 27x27 or 36x18 product. Every product is unsigned and independent of the others. The block does not sum, accumulate or chain them.

Operand A is a 36-bit bus and operand B is a 27-bit bus. The products are packed onto one 64-bit result bus. That bus either passes through a 64-bit output register or bypasses it. The register has a clock enable and an asynchronous clear. The clear is also how the slice is brought out of power-up.

Control pins are plain levels and there is no handshake. The mode and bypass inputs are meant to be static in use, but a change to either takes effect at once. Data moves every cycle, and the register path is paced only by the clock enable.

Top module: `vpm_slice`

## Requirements
- R1: Mode code 0 gives three 9x9 products. Lane i multiplies A[9i+8:9i] by B[9i+8:9i] and places the 18-bit product at result[18i+17:18i]. Result bits 63:54 are zero.
- R2: Mode code 1 gives two 16x16 products. Lane i multiplies A[16i+15:16i] by B[16i+15:16i], with B bits above 26 read as zero. Lane 0 drives result[31:0] and lane 1 drives result[63:32].
- R3: Mode code 2 drives result[35:0] with A[17:0] times B[17:0]. All higher result bits are zero.
- R4: Mode code 3 drives result[53:0] with A[26:0] times B[26:0]. All higher result bits are zero.
- R5: Mode code 4 drives result[53:0] with A[35:0] times B[17:0]. All higher result bits are zero.
- R6: Mode codes 5, 6 and 7 drive a result of zero.
- R7: Operand bits outside the fields named for the selected mode have no effect on the result.
- R8: With bypass low and the enable high, the result takes the product of the operands present at a rising clock edge. This gives one cycle of latency.
- R9: With bypass low and the enable low at a rising edge, the result keeps its value.
- R10: While the clear is high, the register holds zero at once and independently of the clock. It also holds zero after power-up.
- R11: With bypass high, the result is the combinational product of the current inputs, with zero cycles of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Asynchronous clear of the output register, active high |
| ena | input | 1 | Output register load enable |
| bypass | input | 1 | High selects the combinational result |
| mode | input | 3 | Configuration code (0..4 valid) |
| opa | input | 36 | Operand A |
| opb | input | 27 | Operand B |
| result | output | 64 | Packed product bus |

## Verification
Two pairs of functions can act in the same cycle. The first is the asynchronous clear meeting a register load. The second is a bypass change meeting a register that is holding a value. The bench raises the clear while the enable is high and keeps driving operands. It also toggles bypass and the enable at random every cycle. A behavioural model follows the same cycle sequence and gives the clear priority over any load. Each output is compared against that model, which tracks whether the register last cleared, loaded or held.

// File: rtl/vpm_pkg.sv
package vpm_pkg;
  localparam int unsigned A_W    = 36;
  localparam int unsigned B_W    = 27;
  localparam int unsigned RES_W  = 64;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned N9     = 3;
  localparam int unsigned W9     = 9;
  localparam int unsigned N16    = 2;
  localparam int unsigned W16    = 16;
  localparam int unsigned BX_W   = N16 * W16;

  typedef enum logic [MODE_W-1:0] {
    MD_TRI9   = 3'd0,
    MD_DUAL16 = 3'd1,
    MD_ONE18  = 3'd2,
    MD_ONE27  = 3'd3,
    MD_W36X18 = 3'd4
  } vpm_mode_e;
endpackage

// File: rtl/vpm_mul.sv
module vpm_mul #(
  parameter int unsigned WA = 9,
  parameter int unsigned WB = 9,
  localparam int unsigned WP = WA + WB
) (
  input  logic [WA-1:0] a,
  input  logic [WB-1:0] b,
  output logic [WP-1:0] p
);
  always_comb p = WP'(a) * WP'(b);
endmodule

// File: rtl/vpm_outreg.sv
module vpm_outreg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ena,
  input  logic         bypass,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_ff @(posedge clk or posedge clr) begin
    if (clr)      held <= '0;
    else if (ena) held <= d;
  end

  always_comb q = bypass ? d : held;

  assert_load_R8: assert property (@(posedge clk) disable iff (clr)
    ena |=> held == $past(d));
  assert_hold_R9: assert property (@(posedge clk) disable iff (clr)
    !ena |=> $stable(held));
endmodule

// File: rtl/vpm_slice.sv
module vpm_slice
  import vpm_pkg::*;
(
  input  logic                clk,
  input  logic                clr,
  input  logic                ena,
  input  logic                bypass,
  input  logic [MODE_W-1:0]   mode,
  input  logic [A_W-1:0]      opa,
  input  logic [B_W-1:0]      opb,
  output logic [RES_W-1:0]    result
);
  localparam int unsigned P9_W  = 2 * W9;
  localparam int unsigned P16_W = 2 * W16;
  localparam int unsigned PW_W  = A_W + B_W;
  localparam int unsigned PAD9  = RES_W - N9 * P9_W;

  logic              is9, is16;
  logic [BX_W-1:0]   opb_x;
  logic [P9_W-1:0]   p9  [N9];
  logic [P16_W-1:0]  p16 [N16];
  logic [A_W-1:0]    wa;
  logic [B_W-1:0]    wb;
  logic [PW_W-1:0]   pw;
  logic [RES_W-1:0]  comb_res;

  always_comb begin
    is9   = (mode == MD_TRI9);
    is16  = (mode == MD_DUAL16);
    opb_x = BX_W'(opb);
  end

  for (genvar i = 0; i < N9; i++) begin : g_l9
    vpm_mul #(.WA(W9), .WB(W9)) u_m (
      .a (is9 ? opa[W9*i +: W9] : '0),
      .b (is9 ? opb[W9*i +: W9] : '0),
      .p (p9[i])
    );
  end

  for (genvar j = 0; j < N16; j++) begin : g_l16
    vpm_mul #(.WA(W16), .WB(W16)) u_m (
      .a (is16 ? opa[W16*j +: W16] : '0),
      .b (is16 ? opb_x[W16*j +: W16] : '0),
      .p (p16[j])
    );
  end

  // wide shared multiplier; operands masked per single-product mode
  always_comb begin
    wa = '0;
    wb = '0;
    unique case (mode)
      MD_ONE18:  begin wa = A_W'(opa[17:0]); wb = B_W'(opb[17:0]); end
      MD_ONE27:  begin wa = A_W'(opa[26:0]); wb = opb;             end
      MD_W36X18: begin wa = opa;             wb = B_W'(opb[17:0]); end
      default:   ;
    endcase
  end

  vpm_mul #(.WA(A_W), .WB(B_W)) u_wide (.a(wa), .b(wb), .p(pw));

  always_comb begin
    comb_res = '0;
    case (mode)
      MD_TRI9:   comb_res = {{PAD9{1'b0}}, p9[2], p9[1], p9[0]};
      MD_DUAL16: comb_res = {p16[1], p16[0]};
      MD_ONE18, MD_ONE27, MD_W36X18: comb_res = RES_W'(pw);
      default:   comb_res = '0;
    endcase
  end

  vpm_outreg #(.W(RES_W)) u_oreg (
    .clk    (clk),
    .clr    (clr),
    .ena    (ena),
    .bypass (bypass),
    .d      (comb_res),
    .q      (result)
  );

  assert_badmode_zero_R6: assert property (@(posedge clk) disable iff (clr)
    (bypass && mode > 3'd4) |-> result == '0);
  assert_toppad_zero_R1: assert property (@(posedge clk) disable iff (clr)
    (bypass && mode != 3'd1) |-> result[63:54] == '0);
  assert_clear_R10: assert property (@(posedge clk) disable iff (clr)
    (!bypass && $past(clr) && !ena) |-> result == '0);
endmodule

// File: tb/sim_vpm_slice.sv
module sim_vpm_slice;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic        ena = 1'b0;
  logic        bypass = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [35:0] opa = '0;
  logic [26:0] opb = '0;
  logic [63:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] exp_q = '0;
  string       q_tag = "R10";

  vpm_slice u0 (.clk(clk), .clr(clr), .ena(ena), .bypass(bypass),
                .mode(mode), .opa(opa), .opb(opb), .result(result));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [63:0] ref_prod(input logic [2:0] m,
      input logic [35:0] a, input logic [26:0] b);
    longint unsigned r, x, y;
    r = 0;
    case (m)
      3'd0: for (int i = 0; i < 3; i++) begin
              x = (longint'(a) >> (9*i)) & 64'h1ff;
              y = (longint'(b) >> (9*i)) & 64'h1ff;
              r = r | ((x*y) << (18*i));
            end
      3'd1: for (int i = 0; i < 2; i++) begin
              x = (longint'(a) >> (16*i)) & 64'hffff;
              y = (longint'(b) >> (16*i)) & 64'hffff;
              r = r | ((x*y) << (32*i));
            end
      3'd2: r = (longint'(a) & 64'h3ffff) * (longint'(b) & 64'h3ffff);
      3'd3: r = (longint'(a) & 64'h7ffffff) * longint'(b);
      3'd4: r = longint'(a) * (longint'(b) & 64'h3ffff);
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  // reference register, updated at every rising edge
  always @(posedge clk) begin
    if (clr) begin exp_q = '0; q_tag = "R10"; end
    else if (ena) begin exp_q = ref_prod(mode, opa, opb); q_tag = "R8"; end
    else q_tag = "R9";
  end

  task automatic compare(input string extra);
    logic [63:0] e;
    string tag;
    e   = bypass ? ref_prod(mode, opa, opb) : exp_q;
    tag = bypass ? "R11" : q_tag;
    n_cmp++;
    if (result !== e) begin
      n_bad++;
      $display("FAIL %s/%s%s mode=%0d actual=%h expected=%h",
               mode_tag(mode), tag, extra, mode, result, e);
    end
  endtask

  // drive at falling edge, settle, compare
  task automatic step(input logic c, input logic en, input logic bp,
      input logic [2:0] m, input logic [35:0] a, input logic [26:0] b,
      input string extra);
    @(negedge clk);
    clr = c; ena = en; bypass = bp; mode = m; opa = a; opb = b;
    if (c) begin exp_q = '0; q_tag = "R10"; end
    #1;
    compare(extra);
  endtask

  initial begin
    // reset state, R10
    step(1'b1, 1'b1, 1'b0, 3'd0, '1, '1, "");
    step(1'b0, 1'b0, 1'b0, 3'd2, '1, '1, "");
    // every mode, random operands and controls
    for (int m = 0; m < 8; m++)
      for (int k = 0; k < 40; k++)
        step(1'b0, 1'($urandom), 1'($urandom), 3'(m),
             {4'($urandom), 32'($urandom)}, 27'($urandom), "");
    // all-ones operands: unused bits must be ignored, R7
    for (int m = 0; m < 8; m++) begin
      step(1'b0, 1'b1, 1'b1, 3'(m), '1, '1, "/R7");
      step(1'b0, 1'b1, 1'b0, 3'(m), '1, '1, "/R7");
      step(1'b0, 1'b0, 1'b0, 3'(m), '0, '0, "/R7");
    end
    // clear arriving with enable high, then bypass toggling over a held value
    for (int k = 0; k < 30; k++)
      step((k % 7) == 3, 1'b1, k[0], 3'(k % 5),
           {4'($urandom), 32'($urandom)}, 27'($urandom), "/R10");
    for (int k = 0; k < 20; k++)
      step(1'b0, k < 1, k[0], 3'(k % 5),
           {4'($urandom), 32'($urandom)}, 27'($urandom), "/R9");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD*200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule